// File: doc/BRIEF.md
# Simultaneous-Mode DAC Retimer

This block sits between an oversampling digital filter and a 16-bit multibit DAC that loads its left and right words in parallel. The filter delivers a bit clock, one serial data line per channel and a latch strobe. Everything is sampled on a master clock that runs at twice the bit rate. The block rebuilds a clean bit clock from master-clock flip-flops. It retimes both data lines and the latch strobe so that data changes on the falling edge of the rebuilt clock and holds still across its rising edge, which is where the DAC samples.

The block counts the data bits that follow each latch slot. It stops the rebuilt clock after the sixteenth bit, so the DAC keeps the sixteen most significant bits of a longer source word. It can also flip the first bit of every word, which turns a two's-complement source into the offset-binary code the DAC expects. A selectable extra output flip-flop stage adds one master-clock period of delay to all DAC-side lines together. A separate output gives the master clock divided by two, with selectable polarity, to drive the filter.

All outputs come straight from master-clock flip-flops. An active-low synchronous reset clears the design.

Top module: `sim_dac_retimer`

## Requirements
- R1: At every rising mclk edge with rst_n low, all outputs go low after that edge. The data-bit counter is also cleared, so the first slot after reset is bit 0 of a word.
- R2: An input slot is the pair of edges where bck_in is sampled low and then high. Call these edges 2k+S and 2k+S+1 for slot k. With deep_sync=0, the slot's data and latch values appear on dat_l_out, dat_r_out and le_out after edges 2k+S+4 and 2k+S+5. They therefore change only while bck_out is low.
- R3: bck_out is low after edge 2k+S+4. After edge 2k+S+5 it is high for exactly one cycle if the slot is enabled. It is low when idle and is never inverted.
- R4: With deep_sync=1, every DAC-side output (bck_out, data and le_out) appears exactly one mclk cycle later than with deep_sync=0, and their mutual alignment is unchanged.
- R5: Slots are indexed 0, 1, 2 … by data bit since the last latch slot or reset. Only slots with index 0 to 15 produce a bck_out pulse. Indices 16 and above, as in 20- or 24-bit words, produce none.
- R6: A slot with le_in=1 is a latch slot. It drives le_out high for its two output cycles, produces no bck_out pulse, and restarts the index at 0 for the next slot.
- R7: With twos_comp=1, the output bit of index 0 (the MSB) is inverted on both channels. With twos_comp=0, all bits pass unchanged. Latch slots are never inverted.
- R8: fclk_out toggles on every edge after reset. After the m-th edge following reset (m=0 first), it equals div_inv XOR (m odd).
- R9: Consider a 16-bit shift register that shifts dat_l_out or dat_r_out MSB-first on each rising bck_out. When le_out rises, this register holds the source word's top 16 bits, with the MSB inverted when twos_comp=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bck_in | input | 1 | Bit clock from the filter, sampled on mclk |
| dat_l_in | input | 1 | Left serial data, MSB first |
| dat_r_in | input | 1 | Right serial data, MSB first |
| le_in | input | 1 | Latch strobe, marks a latch slot |
| twos_comp | input | 1 | 1: invert MSB (two's-complement source) |
| deep_sync | input | 1 | 1: add one output flip-flop stage |
| div_inv | input | 1 | Polarity of the divided clock |
| bck_out | output | 1 | Rebuilt, gated bit clock to the DAC |
| dat_l_out | output | 1 | Retimed left data |
| dat_r_out | output | 1 | Retimed right data |
| le_out | output | 1 | Retimed latch strobe |
| fclk_out | output | 1 | mclk divided by two for the filter |

## Verification
The bench drives frames of 16-, 20- and 24-bit words and compares every output on every cycle with a behavioural model. It also feeds a DAC-side shift register that must hold the expected top 16 bits at each latch pulse. The 16-bit frames check alignment and latency. The longer words show that clock pulses stop after bit 15 rather than passing extra bits. Runs with inversion on and off tell a correct MSB flip from a flip on the wrong bit. Switching the extra stage separates the two latencies. A frame abandoned mid-word and followed by reset shows whether the bit counter is really cleared. The first-word, all-ones and MSB-only patterns expose bit-order and inversion faults.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  // One bundle of DAC-side lines
  typedef struct packed {
    logic bck;
    logic dl;
    logic dr;
    logic le;
  } lane_t;

  // One processed bit slot: data, latch flag, clock enable
  typedef struct packed {
    logic dl;
    logic dr;
    logic le;
    logic en;
  } slot_t;

  // MSB inversion: only bit index 0 of a data slot
  function automatic logic fix_bit(input logic b, input int unsigned idx,
                                   input logic inv, input logic latch);
    return b ^ (inv & ~latch & (idx == 0));
  endfunction

  // Clock pulse allowed only for the first lim data bits
  function automatic logic gate_on(input int unsigned idx, input int unsigned lim,
                                   input logic latch);
    return ~latch & (idx < lim);
  endfunction

  // Saturating bit counter step
  function automatic int unsigned sat_step(input int unsigned c, input int unsigned top);
    return (c >= top) ? top : c + 1;
  endfunction

endpackage

// File: rtl/sdr_capture.sv
module sdr_capture
  import sdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lane_t      raw,
  output logic [2:0] cap_d,
  output logic       rise
);
  lane_t s1;
  logic  b2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      b2 <= 1'b0;
    end else begin
      s1 <= raw;
      b2 <= s1.bck;
    end
  end

  // bit slot boundary: sampled bit clock just went high
  assign rise  = s1.bck & ~b2;
  assign cap_d = {s1.dl, s1.dr, s1.le};
endmodule

// File: rtl/sdr_framer.sv
module sdr_framer
  import sdr_pkg::*;
#(
  parameter int unsigned DAC_W    = 16,
  parameter int unsigned MAX_BITS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cap_d,
  input  logic       rise,
  input  logic       twos,
  output slot_t      slot,
  output logic       strobe
);
  localparam int unsigned CNT_W = $clog2(MAX_BITS + 1);

  logic [CNT_W-1:0] cnt;
  int unsigned      idx;
  slot_t            nxt;
  logic             c_le;

  assign idx  = 32'(cnt);
  assign c_le = cap_d[0];

  always_comb begin
    nxt.dl = fix_bit(cap_d[2], idx, twos, c_le);
    nxt.dr = fix_bit(cap_d[1], idx, twos, c_le);
    nxt.le = c_le;
    nxt.en = gate_on(idx, DAC_W, c_le);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      slot   <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= rise;
      if (rise) begin
        slot <= nxt;
        cnt  <= c_le ? '0 : CNT_W'(sat_step(idx, MAX_BITS));
      end
    end
  end
endmodule

// File: rtl/sdr_align.sv
module sdr_align
  import sdr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t slot,
  input  logic  strobe,
  input  logic  deep,
  output lane_t dac
);
  logic       bck_g;
  logic       bck_h;
  logic [2:0] dh;
  lane_t      nxt;
  lane_t      stg_a;

  assign nxt = '{bck: bck_h, dl: dh[2], dr: dh[1], le: dh[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_g <= 1'b0;
      bck_h <= 1'b0;
      dh    <= '0;
      stg_a <= '0;
      dac   <= '0;
    end else begin
      bck_g <= strobe & slot.en;         // clock pulse at slot middle
      bck_h <= bck_g;                    // one more period: data leads clock
      dh    <= {slot.dl, slot.dr, slot.le}; // half-bit retime flop
      stg_a <= nxt;
      dac   <= deep ? stg_a : nxt;
    end
  end

  // R3: rebuilt clock pulses last one master-clock cycle
  a_r3_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dac.bck |=> !dac.bck);

  // R2: data and latch hold still while the DAC clock is high
  a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dac.bck |-> ($stable(dac.dl) && $stable(dac.dr) && $stable(dac.le)));
endmodule

// File: rtl/sdr_fdiv.sv
module sdr_fdiv (
  input  logic clk,
  input  logic rst_n,
  input  logic inv,
  output logic fclk
);
  logic tg;
  logic run1;
  logic run2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tg   <= 1'b0;
      fclk <= 1'b0;
      run1 <= 1'b0;
      run2 <= 1'b0;
    end else begin
      tg   <= ~tg;
      fclk <= tg ^ inv;
      run1 <= 1'b1;
      run2 <= run1;
    end
  end

  // R8: divided clock changes level every edge once running
  a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    run2 |-> (fclk != $past(fclk)));
endmodule

// File: rtl/sim_dac_retimer.sv
module sim_dac_retimer
  import sdr_pkg::*;
#(
  parameter int unsigned DAC_W    = 16,
  parameter int unsigned MAX_BITS = 32
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic bck_in,
  input  logic dat_l_in,
  input  logic dat_r_in,
  input  logic le_in,
  input  logic twos_comp,
  input  logic deep_sync,
  input  logic div_inv,
  output logic bck_out,
  output logic dat_l_out,
  output logic dat_r_out,
  output logic le_out,
  output logic fclk_out
);
  localparam int unsigned PW = $clog2(DAC_W + 1);

  lane_t      raw;
  logic [2:0] cap_d;
  logic       rise;
  slot_t      slot;
  logic       strobe;
  lane_t      dac;

  assign raw = '{bck: bck_in, dl: dat_l_in, dr: dat_r_in, le: le_in};

  sdr_capture i_cap (
    .clk(mclk), .rst_n(rst_n), .raw(raw), .cap_d(cap_d), .rise(rise)
  );

  sdr_framer #(.DAC_W(DAC_W), .MAX_BITS(MAX_BITS)) i_frm (
    .clk(mclk), .rst_n(rst_n), .cap_d(cap_d), .rise(rise), .twos(twos_comp),
    .slot(slot), .strobe(strobe)
  );

  sdr_align i_aln (
    .clk(mclk), .rst_n(rst_n), .slot(slot), .strobe(strobe), .deep(deep_sync),
    .dac(dac)
  );

  sdr_fdiv i_div (
    .clk(mclk), .rst_n(rst_n), .inv(div_inv), .fclk(fclk_out)
  );

  assign bck_out   = dac.bck;
  assign dat_l_out = dac.dl;
  assign dat_r_out = dac.dr;
  assign le_out    = dac.le;

  // pulses seen by the DAC since its last latch
  logic [PW-1:0] pcnt;
  always_ff @(posedge mclk) begin
    if (!rst_n)                       pcnt <= '0;
    else if (le_out)                  pcnt <= '0;
    else if (bck_out && 32'(pcnt) < DAC_W) pcnt <= pcnt + 1'b1;
  end

  // R5: never more than DAC_W clock pulses per word
  a_r5_trunc: assert property (@(posedge mclk) disable iff (!rst_n)
    bck_out |-> (32'(pcnt) < DAC_W));

  // R6: no clock pulse during the latch slot
  a_r6_latch_quiet: assert property (@(posedge mclk) disable iff (!rst_n)
    le_out |-> !bck_out);

  // R1: reset drives every output low
  a_r1_reset_low: assert property (@(posedge mclk)
    !rst_n |=> (!bck_out && !dat_l_out && !dat_r_out && !le_out && !fclk_out));
endmodule

// File: tb/test_sim_dac_retimer.sv
module test_sim_dac_retimer;
  logic mclk = 1'b0;
  always #10 mclk = ~mclk;

  logic rst_n = 1'b0, bck_in = 1'b0, dat_l_in = 1'b0, dat_r_in = 1'b0, le_in = 1'b0;
  logic twos_comp = 1'b0, deep_sync = 1'b0, div_inv = 1'b0;
  logic bck_out, dat_l_out, dat_r_out, le_out, fclk_out;

  sim_dac_retimer i_sim_dac_retimer (
    .mclk(mclk), .rst_n(rst_n), .bck_in(bck_in), .dat_l_in(dat_l_in),
    .dat_r_in(dat_r_in), .le_in(le_in), .twos_comp(twos_comp),
    .deep_sync(deep_sync), .div_inv(div_inv), .bck_out(bck_out),
    .dat_l_out(dat_l_out), .dat_r_out(dat_r_out), .le_out(le_out),
    .fclk_out(fclk_out)
  );

  int checks = 0;
  int errors = 0;

  // slot list and per-edge expectations
  bit    sl_l[256], sl_r[256], sl_le[256];
  int    si[256];
  bit    x_bk[512], x_dl[512], x_dr[512], x_le[512];
  string x_tb[512], x_td[512];
  logic [15:0] exl[8], exr[8];

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_case(input int nbits, input int nwords, input bit tc,
                          input bit dp, input bit dv, input int limit, input int pat);
    int n, ns, ee, w_cap, k, base;
    logic [31:0] mask, lw, rw;
    logic [15:0] shl, shr;
    bit pb, pl, b;
    // R1: outputs low while reset is held, even with busy inputs
    @(negedge mclk);
    rst_n = 1'b0; twos_comp = tc; deep_sync = dp; div_inv = dv;
    for (int i = 0; i < 3; i++) begin
      bck_in = i[0]; dat_l_in = 1'b1; dat_r_in = 1'b1; le_in = 1'b1;
      @(negedge mclk);
      chk("R1", "bck in reset", bck_out, 0);
      chk("R1", "left in reset", dat_l_out, 0);
      chk("R1", "right in reset", dat_r_out, 0);
      chk("R1", "le in reset", le_out, 0);
      chk("R1", "fclk in reset", fclk_out, 0);
    end
    rst_n = 1'b1;
    // build slots MSB first, one latch slot per word
    mask = (nbits >= 32) ? 32'hFFFF_FFFF : ((32'd1 << nbits) - 1);
    n = 0;
    for (int w = 0; w < nwords; w++) begin
      if (w == 0)      begin lw = mask; rw = 32'd0; end
      else if (w == 1) begin lw = 32'd1 << (nbits - 1); rw = mask >> 1; end
      else begin
        lw = (pat * 32'h9E37_79B9 + w * 32'h7F4A_7C15) & mask;
        rw = (lw ^ 32'h00C3_A55A) & mask;
      end
      exl[w] = 16'((lw >> (nbits - 16)) & 32'hFFFF) ^ (tc ? 16'h8000 : 16'h0);
      exr[w] = 16'((rw >> (nbits - 16)) & 32'hFFFF) ^ (tc ? 16'h8000 : 16'h0);
      for (int j = 0; j < nbits; j++) begin
        sl_l[n] = lw[nbits-1-j]; sl_r[n] = rw[nbits-1-j]; sl_le[n] = 1'b0; si[n] = j; n++;
      end
      sl_l[n] = 1'b0; sl_r[n] = 1'b0; sl_le[n] = 1'b1; si[n] = -1; n++;
    end
    ns = (limit > 0 && limit < n) ? limit : n;
    ee = 2 + 2 * ns + 8 + int'(dp);
    for (int e = 0; e < ee; e++) begin
      x_bk[e] = 0; x_dl[e] = 0; x_dr[e] = 0; x_le[e] = 0; x_tb[e] = "R3"; x_td[e] = "R2";
    end
    for (int s = 0; s < ns; s++) begin
      base = 6 + 2 * s + int'(dp);
      for (int h = 0; h < 2; h++) begin
        b = tc && si[s] == 0;
        x_dl[base+h] = sl_l[s] ^ b; x_dr[base+h] = sl_r[s] ^ b; x_le[base+h] = sl_le[s];
        x_td[base+h] = b ? "R7" : (dp ? "R4" : "R2");
        x_tb[base+h] = (si[s] < 0) ? "R6" : ((si[s] >= 16) ? "R5" : "R3");
      end
      x_bk[base+1] = (si[s] >= 0 && si[s] < 16);
    end
    for (int e = 6 + 2 * ns + int'(dp); e < ee; e++) begin
      x_dl[e] = x_dl[e-1]; x_dr[e] = x_dr[e-1]; x_le[e] = x_le[e-1];
    end
    // drive and compare every cycle
    w_cap = 0; shl = '0; shr = '0; pb = 0; pl = 0;
    for (int e = 0; e < ee; e++) begin
      k = (e - 2) / 2;
      if (e >= 2 && k < ns) begin
        bck_in = 1'((e - 2) % 2); dat_l_in = sl_l[k]; dat_r_in = sl_r[k]; le_in = sl_le[k];
      end else begin
        bck_in = 1'b0; dat_l_in = 1'b0; dat_r_in = 1'b0; le_in = 1'b0;
      end
      @(negedge mclk);
      chk(x_tb[e], "bck_out", bck_out, x_bk[e]);
      chk(x_td[e], "dat_l_out", dat_l_out, x_dl[e]);
      chk(x_td[e], "dat_r_out", dat_r_out, x_dr[e]);
      chk(x_tb[e] == "R6" ? "R6" : x_td[e], "le_out", le_out, x_le[e]);
      chk("R8", "fclk_out", fclk_out, dv ^ e[0]);
      // DAC-side shift register model
      if (bck_out && !pb) begin
        shl = {shl[14:0], dat_l_out}; shr = {shr[14:0], dat_r_out};
      end
      if (le_out && !pl && limit == 0 && w_cap < 8) begin
        chk("R9", "left word at latch", shl, exl[w_cap]);
        chk("R9", "right word at latch", shr, exr[w_cap]);
        w_cap++;
      end
      pb = bck_out; pl = le_out;
    end
    if (limit == 0) chk("R9", "words latched", w_cap, nwords);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL R9 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run_case(16, 3, 1'b0, 1'b0, 1'b0, 0, 1);  // R2 R3 R6 R9 plain 16-bit
    run_case(16, 3, 1'b1, 1'b1, 1'b1, 0, 2);  // R4 R7 R8
    run_case(20, 3, 1'b0, 1'b0, 1'b1, 0, 3);  // R5 20-bit truncation
    run_case(24, 2, 1'b1, 1'b1, 1'b0, 0, 4);  // R5 R7 24-bit
    run_case(20, 2, 1'b0, 1'b0, 1'b0, 7, 5);  // abandoned mid-word
    run_case(16, 2, 1'b1, 1'b0, 1'b0, 0, 6);  // R1 counter cleared: bit 0 inverted
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule